// File: doc/BRIEF.md
# I2C Master Transmit Sequencer

This block is the transmit side of an I2C bus master. A host writes through a small register port: a byte register, a command register with start and stop request bits, and a status register of four interrupt flags. The block drives SCL and SDA as open-drain lines. Each line has a pull-low enable and a returned line level, which passes through a synchronizer. The block produces START, repeated START and STOP conditions, shifts bytes out MSB first and samples the acknowledge bit in the ninth clock.

After every byte the block keeps SCL pulled low. It stays there until the host has cleared every status flag, so the host has unlimited time to decide what comes next. The ACK value never forces that decision. The host may load another byte, request a STOP, or load an address byte and request a repeated START. The chosen action starts as soon as the status register reads zero. If the block releases SDA but finds it low while SCL is high, another master has won the bus. The block then gives up both lines and reports the loss. An address byte with its direction bit set hands control to a master-receiver stage, which lies outside this block.

The SCL half period is a fixed number of clock cycles set by a parameter.

Top module: `i2c_mtx_seq`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low, the status register reads 0, `irq_o` is 0 and `rx_mode_o` is 0.
- R2: A START pulls SDA low while SCL stays released for one half period. Each byte then follows as 8 data clocks, MSB first, plus one ACK clock in which SDA is released. Outside START and STOP, SDA changes only while SCL is low.
- R3: At the end of the ACK clock, status bit 0 (transmit end) is set. Status bit 1 (acknowledge) is set to the inverse of SDA sampled during the ninth SCL high phase.
- R4: While any status bit is 1 after a byte, SCL stays pulled low. Writes to the byte register or the command register do not release it.
- R5: Once the status register reads 0, the pending action runs, whatever the last ACK value was. The priority order is: repeated START (start bit requested and a byte loaded), then STOP, then another data byte.
- R6: A repeated START releases SDA with SCL low, then releases SCL, then produces a START and sends the loaded byte. If that byte came right after a START and its bit 0 is 1, then once the flags are cleared `rx_mode_o` goes to 1 and SCL stays low.
- R7: A STOP pulls SDA low with SCL low, releases SCL, then releases SDA. When this completes, status bit 3 is set and both lines are free. Clearing it returns the block to idle.
- R8: If SDA reads low at the end of an SCL high phase in which the block released it for a data bit, status bit 2 is set. Both lines are then released with no further clocks.
- R9: `irq_o` is 1 exactly when any status bit is 1.
- R10: Host writes use `host_sel` = 0 for the byte register and 1 for commands (bit 0 requests START, bit 1 requests STOP; writing 1 sets the request). Select 2 writes the status register, where each status bit is ANDed with the written bit.
- R11: From idle, a START begins only when a start request is pending, a byte is loaded and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| stat_o | output | 4 | Status flags: 0 transmit end, 1 ACK, 2 arbitration lost, 3 STOP done |
| irq_o | output | 1 | Interrupt, OR of status flags |
| rx_mode_o | output | 1 | Handover to master-receive operation |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |

## Verification
The assertions assume that the host clears status flags only with a write to select 2. They also assume SCL is not stretched by another device, so the block's own SCL enable stands in for the line state. The bench keeps to this. Its slave pulls SDA low only in the ACK clock, and its competing master pulls only SDA, only during a data bit. Every host write is made on its own cycle, away from the clock edge.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BLOW, ST_BHIGH, ST_HOLD, ST_HAND,
    ST_RSA, ST_RSB, ST_SPA, ST_SPB, ST_SPC, ST_DONE
  } seq_st_e;

  localparam int NFLAGS  = 4;
  localparam int FL_TEND = 0;
  localparam int FL_ACK  = 1;
  localparam int FL_LOST = 2;
  localparam int FL_STOP = 3;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/i2c_mtx_sync.sv
module i2c_mtx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= {sr_q[STAGES-2:0], d[i]};
    end
    assign q[i] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_mtx_tick.sv
module i2c_mtx_tick #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(HALF - 1));
    cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
  import i2c_mtx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DW-1:0]     wdata,
  input  logic              take_data,
  input  logic              take_start,
  input  logic              take_stop,
  input  logic              set_tend,
  input  logic              ack_val,
  input  logic              set_lost,
  input  logic              set_stopd,
  output logic [DW-1:0]     data_q,
  output logic              dvld_q,
  output logic              cst_q,
  output logic              csp_q,
  output logic [NFLAGS-1:0] stat_q
);
  logic [DW-1:0]     data_d;
  logic              dvld_d, cst_d, csp_d, upd;
  logic [NFLAGS-1:0] stat_d;

  always_comb begin
    data_d = data_q;
    dvld_d = dvld_q & ~take_data;
    cst_d  = cst_q & ~take_start;
    csp_d  = csp_q & ~take_stop;
    stat_d = stat_q;
    if (we && sel == SEL_DATA) begin
      data_d = wdata;
      dvld_d = 1'b1;
    end
    if (we && sel == SEL_CMD) begin
      cst_d = cst_d | wdata[0];
      csp_d = csp_d | wdata[1];
    end
    if (we && sel == SEL_STAT) stat_d = stat_q & wdata[NFLAGS-1:0];
    if (set_tend) begin
      stat_d[FL_TEND] = 1'b1;
      stat_d[FL_ACK]  = ack_val;
    end
    if (set_lost)  stat_d[FL_LOST] = 1'b1;
    if (set_stopd) stat_d[FL_STOP] = 1'b1;
    upd = we | take_data | take_start | take_stop | set_tend | set_lost | set_stopd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dvld_q <= 1'b0;
      cst_q  <= 1'b0;
      csp_q  <= 1'b0;
      stat_q <= '0;
    end else if (upd) begin
      data_q <= data_d;
      dvld_q <= dvld_d;
      cst_q  <= cst_d;
      csp_q  <= csp_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/i2c_mtx_fsm.sv
module i2c_mtx_fsm
  import i2c_mtx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] data_i,
  input  logic          dvld,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          stat_clear,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          rx_mode,
  output logic          cnt_clr,
  output logic          take_data,
  output logic          take_start,
  output logic          take_stop,
  output logic          set_tend,
  output logic          ack_val,
  output logic          set_lost,
  output logic          set_stopd,
  output logic          in_start,
  output logic          in_stop
);
  localparam int BW = $clog2(DW + 1);

  seq_st_e       st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          addr_q, addr_d, dir_q, dir_d, rxp_q, rxp_d;
  logic          ack_slot;

  assign ack_slot = (bit_q == BW'(DW));

  always_comb begin
    st_d = st_q;  sh_d = sh_q;  bit_d = bit_q;
    addr_d = addr_q;  dir_d = dir_q;  rxp_d = rxp_q;
    take_data = 1'b0;  take_start = 1'b0;  take_stop = 1'b0;
    set_tend = 1'b0;  ack_val = 1'b0;  set_lost = 1'b0;  set_stopd = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_start && dvld && stat_clear) begin
        st_d = ST_START;  take_start = 1'b1;  take_data = 1'b1;
        sh_d = data_i;  dir_d = data_i[0];  addr_d = 1'b1;  bit_d = '0;
      end
      ST_START: if (tick) st_d = ST_BLOW;
      ST_BLOW:  if (tick) st_d = ST_BHIGH;
      ST_BHIGH: if (tick) begin
        if (ack_slot) begin
          set_tend = 1'b1;  ack_val = ~sda_i;
          rxp_d = addr_q & dir_q;  addr_d = 1'b0;  st_d = ST_HOLD;
        end else if (sh_q[DW-1] && !sda_i) begin
          set_lost = 1'b1;  st_d = ST_IDLE;
        end else begin
          sh_d = {sh_q[DW-2:0], 1'b0};  bit_d = bit_q + 1'b1;  st_d = ST_BLOW;
        end
      end
      ST_HOLD, ST_HAND: if (stat_clear) begin
        if (cmd_start && dvld) begin
          st_d = ST_RSA;  take_start = 1'b1;  take_data = 1'b1;
          sh_d = data_i;  dir_d = data_i[0];  addr_d = 1'b1;  bit_d = '0;  rxp_d = 1'b0;
        end else if (cmd_stop) begin
          st_d = ST_SPA;  take_stop = 1'b1;  rxp_d = 1'b0;
        end else if (st_q == ST_HOLD && rxp_q) begin
          st_d = ST_HAND;
        end else if (st_q == ST_HOLD && dvld) begin
          st_d = ST_BLOW;  take_data = 1'b1;
          sh_d = data_i;  addr_d = 1'b0;  bit_d = '0;
        end
      end
      ST_RSA: if (tick) st_d = ST_RSB;
      ST_RSB: if (tick) st_d = ST_START;
      ST_SPA: if (tick) st_d = ST_SPB;
      ST_SPB: if (tick) st_d = ST_SPC;
      ST_SPC: if (tick) begin
        set_stopd = 1'b1;  st_d = ST_DONE;
      end
      ST_DONE: if (stat_clear) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_oe   = (st_q == ST_BLOW) || (st_q == ST_HOLD) || (st_q == ST_HAND) ||
               (st_q == ST_RSA)  || (st_q == ST_SPA);
    unique case (st_q)
      ST_START, ST_SPA, ST_SPB: sda_oe = 1'b1;
      ST_BLOW, ST_BHIGH:        sda_oe = ack_slot ? 1'b0 : ~sh_q[DW-1];
      default:                  sda_oe = 1'b0;
    endcase
    rx_mode  = (st_q == ST_HAND);
    cnt_clr  = (st_q == ST_IDLE) || (st_q == ST_HOLD) || (st_q == ST_HAND) || (st_q == ST_DONE);
    in_start = (st_q == ST_START);
    in_stop  = (st_q == ST_SPC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      addr_q <= 1'b0;
      dir_q  <= 1'b0;
      rxp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      addr_q <= addr_d;
      dir_q  <= dir_d;
      rxp_q  <= rxp_d;
    end
  end
endmodule

// File: rtl/i2c_mtx_seq.sv
module i2c_mtx_seq
  import i2c_mtx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HALF   = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DW-1:0]     host_wdata,
  output logic [NFLAGS-1:0] stat_o,
  output logic              irq_o,
  output logic              rx_mode_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              scl_i,
  input  logic              sda_i
);
  logic [1:0]    line_s;
  logic          tick, cnt_clr;
  logic [DW-1:0] data_q;
  logic          dvld, cst, csp;
  logic          take_data, take_start, take_stop;
  logic          set_tend, ack_val, set_lost, set_stopd;
  logic          in_start, in_stop;

  i2c_mtx_sync #(.STAGES(SYNC_N), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2c_mtx_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick)
  );

  i2c_mtx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel), .wdata(host_wdata),
    .take_data(take_data), .take_start(take_start), .take_stop(take_stop),
    .set_tend(set_tend), .ack_val(ack_val), .set_lost(set_lost), .set_stopd(set_stopd),
    .data_q(data_q), .dvld_q(dvld), .cst_q(cst), .csp_q(csp), .stat_q(stat_o)
  );

  i2c_mtx_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .data_i(data_q), .dvld(dvld),
    .cmd_start(cst), .cmd_stop(csp), .stat_clear(stat_o == '0), .sda_i(line_s[0]),
    .scl_oe(scl_oe_o), .sda_oe(sda_oe_o), .rx_mode(rx_mode_o), .cnt_clr(cnt_clr),
    .take_data(take_data), .take_start(take_start), .take_stop(take_stop),
    .set_tend(set_tend), .ack_val(ack_val), .set_lost(set_lost), .set_stopd(set_stopd),
    .in_start(in_start), .in_stop(in_stop)
  );

  assign irq_o = |stat_o;
endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk
  import i2c_mtx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [1:0]        host_sel,
  input logic [NFLAGS-1:0] stat,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              in_start,
  input logic              in_stop
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != '0 && scl_oe && !(host_we && host_sel == SEL_STAT)) |=> scl_oe);

  assert_tend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FL_TEND]) |-> scl_oe);

  assert_lost_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FL_LOST]) |-> (!scl_oe && !sda_oe));

  assert_stop_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FL_STOP]) |-> (!scl_oe && !sda_oe));

  assert_sda_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> in_start);

  assert_sda_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> in_stop);
endmodule

bind i2c_mtx_seq i2c_mtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .stat(stat_o), .scl_oe(scl_oe_o), .sda_oe(sda_oe_o),
  .in_start(in_start), .in_stop(in_stop)
);

// File: tb/sim_i2c_mtx_seq.sv
module sim_i2c_mtx_seq;
  localparam int EV_START = 256;
  localparam int EV_STOP  = 257;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [3:0] stat_o;
  logic       irq_o, rx_mode_o, scl_oe_o, sda_oe_o;
  logic       scl_line, sda_line;
  logic       ack_en = 1'b1, ack_drv = 1'b0, comp_en = 1'b0, comp_drv = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  assign scl_line = ~scl_oe_o;
  assign sda_line = ~sda_oe_o & ~ack_drv & ~comp_drv;

  i2c_mtx_seq u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .stat_o(stat_o), .irq_o(irq_o), .rx_mode_o(rx_mode_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .scl_i(scl_line), .sda_i(sda_line)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic observe(input int ev);
    if (exp_q.size() == 0) chk(1'b0, "R2 unexpected bus event", ev, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      chk(ev == e, "R2 bus event order/byte", ev, e);
    end
  endtask

  // bus reference model: decodes the wired-AND lines every clock
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] shreg = 8'd0;
  int         bitn = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(irq_o == (stat_o != 4'd0), "R9 irq equals OR of flags", irq_o, stat_o != 4'd0);
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
        observe(EV_START);  bitn = 0;
      end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
        observe(EV_STOP);  bitn = 0;
      end else if (scl_line && !prev_scl) begin
        if (bitn < 8) shreg = {shreg[6:0], sda_line};
        bitn++;
        if (bitn == 8) observe(int'(shreg));
      end else if (!scl_line && prev_scl) begin
        if (bitn == 8) ack_drv = ack_en;
        else if (bitn == 9) begin ack_drv = 1'b0; bitn = 0; end
        if (bitn == 1 && comp_en) comp_drv = 1'b1;
      end
      if (!comp_en) comp_drv = 1'b0;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk); #1;
    host_we = 1'b1;  host_sel = sel;  host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_flag(input int idx, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (stat_o[idx] !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, tag, n, 5000);
  endtask

  initial begin
    idle(4);
    // R1 reset state
    chk(scl_oe_o == 0 && sda_oe_o == 0, "R1 lines free in reset", {scl_oe_o, sda_oe_o}, 0);
    chk(stat_o == 0 && irq_o == 0 && rx_mode_o == 0, "R1 status clear", stat_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(3);
    chk(scl_oe_o == 0 && sda_oe_o == 0 && stat_o == 0, "R1 idle after reset", stat_o, 0);

    // first address byte, slave acks (R2, R3)
    exp_q.push_back(EV_START);  exp_q.push_back(8'hA4);
    hwr(2'd0, 8'hA4);  hwr(2'd1, 8'h01);
    wait_flag(0, "R3 transmit end after address");
    chk(stat_o == 4'b0011, "R3 tend and ack set", stat_o, 4'b0011);
    chk(irq_o == 1, "R9 irq raised", irq_o, 1);
    idle(60);
    chk(scl_oe_o == 1, "R4 SCL held while flags set", scl_oe_o, 1);
    hwr(2'd0, 8'h3C);
    idle(30);
    chk(scl_oe_o == 1, "R4 byte write does not release SCL", scl_oe_o, 1);
    chk(exp_q.size() == 0, "R2 no bus activity while held", exp_q.size(), 0);

    // data byte, slave does not ack (R3)
    ack_en = 1'b0;
    exp_q.push_back(8'h3C);
    hwr(2'd2, 8'h00);
    wait_flag(0, "R3 transmit end after data");
    chk(stat_o == 4'b0001, "R3 nack leaves ack bit clear", stat_o, 4'b0001);

    // continue despite NACK (R5)
    ack_en = 1'b1;
    exp_q.push_back(8'h5A);
    hwr(2'd0, 8'h5A);  hwr(2'd2, 8'h00);
    wait_flag(0, "R5 continue after nack");
    chk(stat_o == 4'b0011, "R5 byte sent after nack", stat_o, 4'b0011);

    // AND-mask status write (R10)
    hwr(2'd2, 8'b1101);
    chk(stat_o == 4'b0001, "R10 status write clears zero bits only", stat_o, 4'b0001);
    idle(20);
    chk(scl_oe_o == 1, "R4 partial clear keeps SCL low", scl_oe_o, 1);

    // repeated START with read address (R6)
    exp_q.push_back(EV_START);  exp_q.push_back(8'hA5);
    hwr(2'd0, 8'hA5);  hwr(2'd1, 8'h01);
    idle(20);
    chk(scl_oe_o == 1, "R4 command write does not release SCL", scl_oe_o, 1);
    hwr(2'd2, 8'h00);
    wait_flag(0, "R6 address after repeated start");
    chk(stat_o == 4'b0011, "R6 address acked", stat_o, 4'b0011);
    hwr(2'd2, 8'h00);
    idle(5);
    chk(rx_mode_o == 1 && scl_oe_o == 1, "R6 handover to receive", {rx_mode_o, scl_oe_o}, 2'b11);

    // STOP from handover (R7)
    exp_q.push_back(EV_STOP);
    hwr(2'd1, 8'h02);
    wait_flag(3, "R7 stop done flag");
    chk(stat_o == 4'b1000, "R7 only stop flag set", stat_o, 4'b1000);
    chk(scl_oe_o == 0 && sda_oe_o == 0 && rx_mode_o == 0, "R7 lines free after stop",
        {scl_oe_o, sda_oe_o, rx_mode_o}, 0);
    hwr(2'd2, 8'h00);
    chk(stat_o == 0, "R7 status cleared", stat_o, 0);

    // arbitration loss in second bit (R8)
    comp_en = 1'b1;
    exp_q.push_back(EV_START);
    hwr(2'd0, 8'hC0);  hwr(2'd1, 8'h01);
    wait_flag(2, "R8 arbitration lost flag");
    chk(stat_o == 4'b0100, "R8 lost flag only", stat_o, 4'b0100);
    chk(scl_oe_o == 0 && sda_oe_o == 0, "R8 lines released", {scl_oe_o, sda_oe_o}, 0);
    idle(40);
    chk(scl_oe_o == 0, "R8 no further clocks", scl_oe_o, 0);
    exp_q.push_back(EV_STOP);
    comp_en = 1'b0;
    idle(5);

    // start blocked while a flag is set (R11)
    hwr(2'd0, 8'h42);  hwr(2'd1, 8'h01);
    idle(40);
    chk(scl_oe_o == 0 && sda_oe_o == 0, "R11 no start while flag set", {scl_oe_o, sda_oe_o}, 0);
    exp_q.push_back(EV_START);  exp_q.push_back(8'h42);
    hwr(2'd2, 8'h00);
    wait_flag(0, "R11 start after clear");
    chk(stat_o == 4'b0011, "R11 byte sent after clear", stat_o, 4'b0011);

    // start has priority over stop (R5)
    exp_q.push_back(EV_START);  exp_q.push_back(8'h99);
    hwr(2'd0, 8'h99);  hwr(2'd1, 8'h03);  hwr(2'd2, 8'h00);
    wait_flag(0, "R5 repeated start first");
    chk(stat_o == 4'b0011, "R5 start before stop", stat_o, 4'b0011);
    exp_q.push_back(EV_STOP);
    hwr(2'd2, 8'h00);
    wait_flag(3, "R5 pending stop runs next");
    chk(stat_o == 4'b1000 && rx_mode_o == 0, "R5 stop before handover", stat_o, 4'b1000);
    hwr(2'd2, 8'h00);
    idle(10);
    chk(exp_q.size() == 0, "R2 all expected events seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule